// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States

This block times the external bus cycles of a 32-bit processor port. The core hands it one request at a time: an address, write data, a wait-state count, a write flag and a read-modify-write flag. The sequencer then walks the bus through its phases. It drives the two active-low strobes whose pair gives the bus status, the read/write line, a bus-lock line and the output enables for the pads. It samples a transfer-acknowledge input through a synchronizer. At the end it returns read data and a one-cycle done pulse.

A cycle stretches until two conditions both hold: the programmed wait count has run out, and the synchronized acknowledge is seen. The effective wait is therefore the larger of the two. A read-modify-write request runs a read, then a write to the same address with no idle phase between them, and the lock line is held low across both. A request that arrives while a cycle is running is held in a one-entry slot. It starts after that cycle returns to idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, the block is idle: `bs_n`=1, `ts_n`=1, `rw`=1, `lock_n`=1, `done`=0 and `rd_data`=0.
- R2: The pair {`bs_n`,`ts_n`} encodes the phase: 11 is idle, 01 is start, 00 is transfer/wait, and 10 is end.
- R3: An accepted cycle runs one start phase, then one or more transfer phases, then one end phase. `ts_n` first goes low in the phase right after start.
- R4: The number of transfer phases is W+1, where W is the larger of `req_wait` and the first transfer phase (counted from 0) in which the synchronized acknowledge is set.
- R5: `xack_n` (active low) passes through a two-stage synchronizer. A level on it is used by the phase logic two clock edges after it is sampled.
- R6: `rw` is 1 during a read cycle, 0 during a write cycle, and 1 whenever the block is idle.
- R7: With `req_rmw`=1 (which overrides `req_write`), a read runs first and its end phase leads directly into the start phase of a write to the same address. `lock_n` is 0 from the read's start phase through the write's end phase, and 1 at all other times.
- R8: `bus_addr` changes only in phases where `ts_n` is 1. It is loaded when a request is accepted and held until the next acceptance.
- R9: `addr_oe` = `bus_master` and not `aen_n`. `ctl_oe` = `bus_master`. `data_oe` is 1 only when `bus_master` is 1 and a write cycle is between its start and end phases, inclusive.
- R10: `rd_data` takes `bus_din` at the end phase of each read. `done` is a one-cycle pulse in the cycle after the last end phase of a request; a read-modify-write pair gives a single pulse.
- R11: A request is accepted only when the block is idle, and its start phase follows one cycle later. A request raised during a cycle is held and starts after that cycle has shown one idle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request pulse from the core |
| req_write | input | 1 | 1 = write, 0 = read (ignored when req_rmw=1) |
| req_rmw | input | 1 | Indivisible read-then-write pair |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_wait | input | WAIT_W | Programmed wait-state count |
| rd_data | output | DATA_W | Data captured from the last read |
| done | output | 1 | One-cycle completion pulse |
| bus_master | input | 1 | Unit owns the bus |
| aen_n | input | 1 | Address-enable input, active low |
| xack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_din | input | DATA_W | Data bus input |
| bus_addr | output | ADDR_W | Address bus |
| bus_dout | output | DATA_W | Data bus output |
| bs_n | output | 1 | Bus strobe, active low |
| ts_n | output | 1 | Transfer strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| lock_n | output | 1 | Bus lock, active low |
| addr_oe | output | 1 | Address pad output enable |
| data_oe | output | 1 | Data pad output enable |
| ctl_oe | output | 1 | Bus-control pad output enable |

## Verification
The bench runs cycles in four patterns. In two, the wait count exceeds the acknowledge delay; in two, the acknowledge comes later than the wait count. A difference in the transfer-phase count therefore shows whether the block takes the larger of the two or only one of them. A zero-wait read with the acknowledge held on shows the shortest legal cycle and the synchronizer latency. A read-modify-write pair separates the direct read-to-write chaining and the held lock from two independent cycles. A request raised mid-cycle shows that the held request waits for idle. Dropping `bus_master` and raising `aen_n` during a write shows that the enables follow their inputs without disturbing the strobes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_XFER  = 2'd2,
      PH_END   = 2'd3
   } bcs_phase_e;

   // {bs_n, ts_n} for a phase
   function automatic logic [1:0] strobe_code(bcs_phase_e ph);
      logic [1:0] code;
      case (ph)
         PH_START: code = 2'b01;
         PH_XFER:  code = 2'b00;
         PH_END:   code = 2'b10;
         default:  code = 2'b11;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("bcs_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= 1'b0;
            else        q_r <= d_in;
         end
         assign q_out = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] chain_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_r <= '0;
            else        chain_r <= {chain_r[STAGES-2:0], d_in};
         end
         assign q_out = chain_r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bcs_wait_ctr.sv
module bcs_wait_ctr #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_val,
   input  logic              step,
   output logic              expired
);
   generate
      if (WAIT_W < 1) begin : g_bad
         $error("bcs_wait_ctr: WAIT_W must be at least 1");
      end
   endgenerate

   logic [WAIT_W-1:0] cnt_r;
   logic              is_zero;

   assign is_zero = (cnt_r == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r <= '0;
      end else if (load) begin
         cnt_r <= load_val;
      end else if (step && !is_zero) begin
         cnt_r <= cnt_r - 1'b1;
      end
   end

   assign expired = is_zero;
endmodule

// File: rtl/bcs_req_hold.sv
module bcs_req_hold #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              take,
   input  logic              in_write,
   input  logic              in_rmw,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [WAIT_W-1:0] in_wait,
   output logic              hold_valid,
   output logic              hold_write,
   output logic              hold_rmw,
   output logic [ADDR_W-1:0] hold_addr,
   output logic [DATA_W-1:0] hold_wdata,
   output logic [WAIT_W-1:0] hold_wait
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_valid <= 1'b0;
         hold_write <= 1'b0;
         hold_rmw   <= 1'b0;
         hold_addr  <= '0;
         hold_wdata <= '0;
         hold_wait  <= '0;
      end else begin
         if (load) begin
            hold_valid <= 1'b1;
            hold_write <= in_write;
            hold_rmw   <= in_rmw;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
            hold_wait  <= in_wait;
         end else if (take) begin
            hold_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int WAIT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_rmw,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WAIT_W-1:0] req_wait,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   input  logic              bus_master,
   input  logic              aen_n,
   input  logic              xack_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bs_n,
   output logic              ts_n,
   output logic              rw,
   output logic              lock_n,
   output logic              addr_oe,
   output logic              data_oe,
   output logic              ctl_oe
);
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus_cycle_seq: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   bcs_phase_e        phase_r, phase_nx;
   logic              cur_write_r;
   logic              rmw_tail_r;
   logic              lock_r;
   logic              done_r;
   logic [ADDR_W-1:0] addr_r;
   logic [DATA_W-1:0] wdata_r;
   logic [DATA_W-1:0] rdata_r;
   logic [WAIT_W-1:0] wait_r;

   logic              ack_sync;
   logic              wait_expired;
   logic              in_idle;
   logic              take_req;
   logic              hold_load;
   logic              hold_take;

   logic              hold_valid, hold_write, hold_rmw;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_wdata;
   logic [WAIT_W-1:0] hold_wait;

   logic              sel_write, sel_rmw;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic [WAIT_W-1:0] sel_wait;

   logic              xfer_leave;
   logic              end_chain;

   // acknowledge synchronizer
   bcs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (~xack_n),
      .q_out (ack_sync)
   );

   // request slot for requests raised while busy
   assign in_idle   = (phase_r == PH_IDLE);
   assign hold_load = req_valid && (!in_idle || hold_valid);
   assign hold_take = in_idle && hold_valid;
   assign take_req  = in_idle && (hold_valid || req_valid);

   bcs_req_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WAIT_W (WAIT_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (hold_load),
      .take       (hold_take),
      .in_write   (req_write),
      .in_rmw     (req_rmw),
      .in_addr    (req_addr),
      .in_wdata   (req_wdata),
      .in_wait    (req_wait),
      .hold_valid (hold_valid),
      .hold_write (hold_write),
      .hold_rmw   (hold_rmw),
      .hold_addr  (hold_addr),
      .hold_wdata (hold_wdata),
      .hold_wait  (hold_wait)
   );

   always_comb begin
      if (hold_valid) begin
         sel_write = hold_write;
         sel_rmw   = hold_rmw;
         sel_addr  = hold_addr;
         sel_wdata = hold_wdata;
         sel_wait  = hold_wait;
      end else begin
         sel_write = req_write;
         sel_rmw   = req_rmw;
         sel_addr  = req_addr;
         sel_wdata = req_wdata;
         sel_wait  = req_wait;
      end
   end

   // wait-state counter, loaded at the start phase
   bcs_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_r == PH_START),
      .load_val (wait_r),
      .step     (phase_r == PH_XFER),
      .expired  (wait_expired)
   );

   assign xfer_leave = wait_expired && ack_sync;
   assign end_chain  = rmw_tail_r;

   always_comb begin
      phase_nx = phase_r;
      case (phase_r)
         PH_IDLE:  if (take_req) phase_nx = PH_START;
         PH_START: phase_nx = PH_XFER;
         PH_XFER:  if (xfer_leave) phase_nx = PH_END;
         PH_END:   phase_nx = end_chain ? PH_START : PH_IDLE;
         default:  phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_r     <= PH_IDLE;
         cur_write_r <= 1'b0;
         rmw_tail_r  <= 1'b0;
         lock_r      <= 1'b0;
         done_r      <= 1'b0;
         addr_r      <= '0;
         wdata_r     <= '0;
         rdata_r     <= '0;
         wait_r      <= '0;
      end else begin
         phase_r <= phase_nx;
         done_r  <= 1'b0;
         case (phase_r)
            PH_IDLE: begin
               if (take_req) begin
                  addr_r      <= sel_addr;
                  wdata_r     <= sel_wdata;
                  wait_r      <= sel_wait;
                  rmw_tail_r  <= sel_rmw;
                  cur_write_r <= sel_rmw ? 1'b0 : sel_write;
                  lock_r      <= sel_rmw;
               end
            end
            PH_END: begin
               if (!cur_write_r) rdata_r <= bus_din;
               if (end_chain) begin
                  cur_write_r <= 1'b1;
                  rmw_tail_r  <= 1'b0;
               end else begin
                  cur_write_r <= 1'b0;
                  lock_r      <= 1'b0;
                  done_r      <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // outputs
   logic [1:0] code;
   assign code     = strobe_code(phase_r);
   assign bs_n     = code[1];
   assign ts_n     = code[0];
   assign rw       = !(cur_write_r && !in_idle);
   assign lock_n   = !lock_r;
   assign bus_addr = addr_r;
   assign bus_dout = wdata_r;
   assign rd_data  = rdata_r;
   assign done     = done_r;
   assign ctl_oe   = bus_master;
   assign addr_oe  = bus_master && !aen_n;
   assign data_oe  = bus_master && cur_write_r && !in_idle;

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bs_n,
   input logic              ts_n,
   input logic              rw,
   input logic              lock_n,
   input logic              done,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              ack_s
);
   AST_START_TO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (!bs_n && ts_n) |=> (!bs_n && !ts_n)); // R3

   AST_TS_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ts_n) |-> $past(!bs_n && ts_n)); // R3

   AST_END_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bs_n && !ts_n) |-> $past(ack_s)); // R4

   AST_IDLE_READS: assert property (@(posedge clk) disable iff (!rst_n)
      (bs_n && ts_n) |-> rw); // R6

   AST_LOCK_FREE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!lock_n && bs_n && ts_n)); // R7

   AST_LOCK_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_n) |-> $past(bs_n && !ts_n)); // R7

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_n |-> $stable(bus_addr)); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bs_n && !ts_n)); // R10
endmodule

bind bus_cycle_seq bcs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bs_n     (bs_n),
   .ts_n     (ts_n),
   .rw       (rw),
   .lock_n   (lock_n),
   .done     (done),
   .bus_addr (bus_addr),
   .ack_s    (ack_sync)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
   localparam int CLK_P  = 10;
   localparam int AW     = 32;
   localparam int DW     = 32;
   localparam int WW     = 4;
   localparam int WD_LIM = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0, req_rmw = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [WW-1:0] req_wait = '0;
   logic [DW-1:0] rd_data;
   logic          done;
   logic          bus_master = 1'b1, aen_n = 1'b0, xack_n = 1'b1;
   logic [DW-1:0] bus_din = 32'h1234_5679;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dout;
   logic          bs_n, ts_n, rw, lock_n, addr_oe, data_oe, ctl_oe;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   bus_cycle_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_rmw(req_rmw),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wait(req_wait),
      .rd_data(rd_data), .done(done),
      .bus_master(bus_master), .aen_n(aen_n), .xack_n(xack_n),
      .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bs_n(bs_n), .ts_n(ts_n), .rw(rw), .lock_n(lock_n),
      .addr_oe(addr_oe), .data_oe(data_oe), .ctl_oe(ctl_oe)
   );

   // ---------------- reference model ----------------
   typedef struct {
      bit          wr;
      bit          rmw;
      logic [31:0] a;
      logic [31:0] d;
      int          wt;
   } breq_t;

   breq_t       pq[$];
   int          m_ph = 0;      // 0 idle, 1 start, 2 xfer, 3 end
   int          m_xc = 0;
   int          m_wt = 0;
   bit          m_isw = 0, m_tail = 0, m_lock = 0, m_done = 0;
   logic [31:0] m_addr = '0, m_wd = '0, m_rd = '0;
   bit          s1 = 0, s2 = 0;
   int          m_ndone = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pq.delete();
         m_ph = 0; m_xc = 0; m_wt = 0; m_isw = 0; m_tail = 0;
         m_lock = 0; m_done = 0; m_addr = '0; m_wd = '0; m_rd = '0;
         s1 = 0; s2 = 0;
      end else begin
         bit    used_ack;
         bit    nd;
         breq_t live;
         used_ack = s2;
         s2 = s1;
         s1 = !xack_n;
         nd = 0;
         live.wr = req_write; live.rmw = req_rmw; live.a = req_addr;
         live.d = req_wdata;  live.wt = int'(req_wait);
         if (m_ph == 0) begin
            breq_t t;
            bit    go;
            go = 0;
            if (pq.size() > 0) begin
               t = pq.pop_front(); go = 1;
               if (req_valid) pq.push_back(live);
            end else if (req_valid) begin
               t = live; go = 1;
            end
            if (go) begin
               m_ph = 1; m_addr = t.a; m_wd = t.d; m_wt = t.wt;
               m_tail = t.rmw; m_isw = t.rmw ? 0 : t.wr; m_lock = t.rmw;
            end
         end else begin
            if (req_valid) pq.push_back(live);
            case (m_ph)
               1: begin m_ph = 2; m_xc = 0; end
               2: begin
                  if (m_xc >= m_wt && used_ack) m_ph = 3;
                  else m_xc++;
               end
               default: begin
                  if (!m_isw) m_rd = bus_din;
                  if (m_tail) begin
                     m_ph = 1; m_isw = 1; m_tail = 0;
                  end else begin
                     m_ph = 0; m_isw = 0; m_lock = 0; nd = 1;
                  end
               end
            endcase
         end
         m_done = nd;
         if (nd) m_ndone++;
      end
   end

   // ---------------- checks ----------------
   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   logic          prev_ts = 1'b1;
   logic [AW-1:0] prev_addr = '0;
   bit            cmp_on = 0;

   always @(negedge clk) begin
      if (cmp_on) begin
         bit e_bs, e_ts;
         e_bs = !(m_ph == 1 || m_ph == 2);
         e_ts = !(m_ph == 2 || m_ph == 3);
         chk("R2 R3 R4 R5 R11 bs_n", bs_n, e_bs);
         chk("R2 R3 R4 R5 R11 ts_n", ts_n, e_ts);
         chk("R6 rw", rw, !(m_ph != 0 && m_isw));
         chk("R7 lock_n", lock_n, !m_lock);
         chk("R8 R11 bus_addr", bus_addr, m_addr);
         chk("R10 done", done, m_done);
         chk("R10 rd_data", rd_data, m_rd);
         chk("R9 addr_oe", addr_oe, bus_master && !aen_n);
         chk("R9 ctl_oe", ctl_oe, bus_master);
         chk("R9 data_oe", data_oe, bus_master && m_ph != 0 && m_isw);
         if (data_oe) chk("R9 bus_dout", bus_dout, m_wd);
         if (!ts_n && !prev_ts) chk("R8 addr stable while ts_n low", bus_addr, prev_addr);
      end
      prev_ts   = ts_n;
      prev_addr = bus_addr;
   end

   // acknowledge source: asserted once ts_n has been low for ack_dly samples
   int ack_dly = 0;
   int tcnt = 0;
   always @(negedge clk) begin
      if (!ts_n) tcnt++;
      else       tcnt = 0;
      xack_n = !(tcnt >= ack_dly);
      bus_din = {bus_din[30:0], bus_din[31] ^ bus_din[21] ^ bus_din[1] ^ bus_din[0]};
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic issue(input bit wr, input bit rmw, input logic [31:0] a,
                        input logic [31:0] d, input int wt);
      step();
      req_valid = 1'b1; req_write = wr; req_rmw = rmw;
      req_addr = a; req_wdata = d; req_wait = WW'(wt);
      step();
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input int tgt);
      wait (m_ndone >= tgt);
      repeat (2) step();
   endtask

   task automatic run_all();
      int n;
      n = 0;
      // R1: reset values
      step();
      chk("R1 bs_n", bs_n, 1'b1);
      chk("R1 ts_n", ts_n, 1'b1);
      chk("R1 rw", rw, 1'b1);
      chk("R1 lock_n", lock_n, 1'b1);
      chk("R1 done", done, 1'b0);
      chk("R1 rd_data", rd_data, '0);
      rst_n = 1'b1;
      cmp_on = 1;
      repeat (3) step();

      // zero-wait read, ack held on (R4 R5 minimum length)
      ack_dly = 0;
      issue(0, 0, 32'h0000_1000, 32'h0, 0); n++; wait_done(n);
      // write, wait count longer than ack
      issue(1, 0, 32'h0000_2004, 32'hA5A5_0001, 3); n++; wait_done(n);
      // read, ack later than wait count
      ack_dly = 6;
      issue(0, 0, 32'h0000_3008, 32'h0, 1); n++; wait_done(n);
      // write, wait count dominates a short ack delay
      ack_dly = 2;
      issue(1, 0, 32'h0000_400C, 32'h5A5A_0002, 7); n++; wait_done(n);
      // R7: read-modify-write pair
      ack_dly = 1;
      issue(0, 1, 32'h0000_5010, 32'hC0DE_0003, 2); n++; wait_done(n);
      // R7: rmw with req_write set is still read first
      ack_dly = 4;
      issue(1, 1, 32'h0000_5014, 32'hC0DE_0004, 0); n++; wait_done(n);
      // R11: second request raised mid-cycle is held
      ack_dly = 3;
      issue(0, 0, 32'h0000_6018, 32'h0, 2);
      step();
      issue(1, 0, 32'h0000_701C, 32'hBEEF_0005, 1);
      n += 2; wait_done(n);
      // R9: enables follow bus_master / aen_n during a write
      ack_dly = 2;
      issue(1, 0, 32'h0000_8020, 32'h1357_0006, 4);
      step(); bus_master = 1'b0;
      step(); aen_n = 1'b1;
      step(); bus_master = 1'b1;
      n++; wait_done(n);
      aen_n = 1'b0;
      // long wait count at the top of its range
      ack_dly = 0;
      issue(0, 0, 32'h0000_9024, 32'h0, 15); n++; wait_done(n);
      repeat (4) step();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (WD_LIM) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog R10 R11 actual=no completion expected=all done");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule